// File: doc/BRIEF.md
# Protected Memory Window Router

This block sits in a memory controller's address decode path. Each physical memory request arrives with an address, a read/write flag and a flag that says whether the requester is running in system-management mode (SMM). The block decides where that request goes: to DRAM, to the legacy video buffer, or nowhere. A request that goes nowhere is dropped. A dropped read returns all ones, and a dropped write is discarded.

Two configuration registers steer the decision. They are written through a simple configuration port.

- The window control byte enables the fixed legacy window at 0xA0000–0xBFFFF. It also holds a lock bit and an "open" bit. The open bit lets requests made outside SMM reach the protected memory behind that window.
- The protected segment register sets the lower bound of a second region. That region ends just below a fixed top address. The register carries its own lock bit.

Both lock bits are sticky until reset. Firmware programs the registers during boot and then locks them. After that, code running outside SMM can no longer reopen the protected memory or move the protected segment.

Requests are registered on a strobe. The routing result is presented on the following cycle.

Top module: `smram_route_dec`

## Requirements
- R1: After reset, the window control byte reads 0x00. The protected segment register reads back the top address 0xAB800000, which makes the segment empty. No response is valid.
- R2: A request accepted on a clock edge with `req_valid` high produces `rsp_valid` high for exactly the following cycle, carrying that request's address. A cycle without a request produces no response, and back-to-back requests produce back-to-back responses.
- R3: Addresses outside both the legacy window and the protected segment route to DRAM (route code 2'b00) in either mode. This includes 0x9FFFF and 0xC0000.
- R4: With the enable bit (bit 3 of the control byte) clear, every request to 0xA0000–0xBFFFF routes to video (2'b01), whatever the mode.
- R5: With the enable bit set, an SMM request to the legacy window routes to DRAM. A non-SMM request to the window routes to video while the open bit is clear.
- R6: With the enable and open bits (bit 6) both set, a non-SMM request to the legacy window routes to DRAM.
- R7: A configuration write with `cfg_sel`=0 stores `cfg_wdata[7:0]` into the control byte, and `cfg_sel`=0 reads it back on `cfg_rdata[7:0]`.
- R8: Control byte locking works as follows:
  - Bit 4 is the lock bit.
  - A write that sets bit 4 stores bit 6 as 0.
  - Once bit 4 is set, later control writes have no effect.
  - The lock clears only on reset.
- R9: The protected segment register is written with `cfg_sel`=1. It holds the base in bits [31:20] and its lock in bit 0, and reads back in the same layout. Once the lock is set, later writes have no effect until reset.
- R10: A request with base ≤ address < 0xAB800000 is inside the protected segment. Inside it, a non-SMM request routes to drop (2'b10) even when the open bit is set, and an SMM request routes to DRAM. The segment check takes priority over the legacy window.
- R11: On a dropped read, `rsp_fill_ones` is 1. A dropped write gives `rsp_wr_en`=0. Writes routed to DRAM or video give `rsp_wr_en`=1, and `rsp_fill_ones` is 0 for every non-dropped response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control byte, 1 protected segment |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request physical address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_smm | input | 1 | Requester is in system-management mode |
| rsp_valid | output | 1 | Routing result valid |
| rsp_addr | output | 32 | Address of the routed request |
| rsp_route | output | 2 | 00 DRAM, 01 video, 10 drop |
| rsp_wr_en | output | 1 | Write is forwarded to its target |
| rsp_fill_ones | output | 1 | Read data is forced to all ones |

## Verification
The hardest state to reach from the ports is a locked configuration that still tries to reopen the window. The stimulus first enables and opens the window. It then writes the lock together with the open bit, so the lock write itself must clear open. Further write attempts follow to confirm that the frozen byte keeps non-SMM traffic on video.

A second hard case is an overlap. With the window open, the protected segment is placed and then locked. Non-SMM traffic at its base and just below its top must be dropped, while addresses one below the base and at the top must pass to DRAM.

// File: rtl/smram_route_pkg.sv
package smram_route_pkg;

  localparam int PA_W = 32;

  // control byte bit positions
  localparam int WC_EN_BIT   = 3;
  localparam int WC_LOCK_BIT = 4;
  localparam int WC_OPEN_BIT = 6;
  localparam int WC_W        = 8;

  typedef enum logic [1:0] {
    RT_DRAM  = 2'b00,
    RT_VIDEO = 2'b01,
    RT_DROP  = 2'b10
  } route_e;

  function automatic logic addr_between(input logic [PA_W-1:0] a,
                                        input logic [PA_W-1:0] lo,
                                        input logic [PA_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // protected segment outranks the legacy window
  function automatic route_e pick_route(input logic in_seg,
                                        input logic in_win,
                                        input logic smm,
                                        input logic win_en,
                                        input logic win_open);
    if (in_seg) return smm ? RT_DRAM : RT_DROP;
    if (in_win) begin
      if (win_en && (smm || win_open)) return RT_DRAM;
      return RT_VIDEO;
    end
    return RT_DRAM;
  endfunction

  // lock write forces the open bit low
  function automatic logic [WC_W-1:0] ctl_store(input logic [WC_W-1:0] wd);
    logic [WC_W-1:0] v;
    v = wd;
    if (wd[WC_LOCK_BIT]) v[WC_OPEN_BIT] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_route_pkg::*;
#(
  parameter int              AW      = PA_W,
  parameter int              GRAN_W  = 20,
  parameter logic [AW-1:0]   SEG_TOP = 32'hAB80_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic [AW-1:0]   cfg_rdata,
  output logic [WC_W-1:0] win_ctl,
  output logic [AW-1:0]   seg_base,
  output logic            seg_lock,
  output logic            ctl_wr_take,
  output logic            seg_wr_take
);
  localparam int BASE_W = AW - GRAN_W;
  localparam logic [BASE_W-1:0] BASE_RST = SEG_TOP[AW-1:GRAN_W];

  logic [WC_W-1:0]   ctl_q;
  logic [BASE_W-1:0] base_q;
  logic              lock_q;

  assign ctl_wr_take = cfg_we && !cfg_sel && !ctl_q[WC_LOCK_BIT];
  assign seg_wr_take = cfg_we &&  cfg_sel && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr_take) begin
      ctl_q <= ctl_store(cfg_wdata[WC_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      lock_q <= 1'b0;
    end else if (seg_wr_take) begin
      base_q <= cfg_wdata[AW-1:GRAN_W];
      lock_q <= cfg_wdata[0];
    end
  end

  assign win_ctl  = ctl_q;
  assign seg_base = {base_q, {GRAN_W{1'b0}}};
  assign seg_lock = lock_q;

  always_comb begin
    if (cfg_sel) cfg_rdata = {base_q, {(GRAN_W-1){1'b0}}, lock_q};
    else         cfg_rdata = {{(AW-WC_W){1'b0}}, ctl_q};
  end
endmodule

// File: rtl/smram_req_stage.sv
module smram_req_stage
  import smram_route_pkg::*;
#(
  parameter int AW = PA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_smm,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output logic          q_write,
  output logic          q_smm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_write <= 1'b0;
      q_smm   <= 1'b0;
    end else if (req_valid) begin
      q_addr  <= req_addr;
      q_write <= req_write;
      q_smm   <= req_smm;
    end
  end
endmodule

// File: rtl/smram_route_logic.sv
module smram_route_logic
  import smram_route_pkg::*;
#(
  parameter int            AW        = PA_W,
  parameter logic [AW-1:0] WIN_LO    = 32'h000A_0000,
  parameter logic [AW-1:0] WIN_HI    = 32'h000B_FFFF,
  parameter logic [AW-1:0] SEG_TOP   = 32'hAB80_0000
) (
  input  logic            q_valid,
  input  logic [AW-1:0]   q_addr,
  input  logic            q_write,
  input  logic            q_smm,
  input  logic [WC_W-1:0] win_ctl,
  input  logic [AW-1:0]   seg_base,
  output logic [1:0]      route,
  output logic            wr_en,
  output logic            fill_ones,
  output logic            hit_win,
  output logic            hit_seg
);
  route_e r;

  assign hit_win = addr_between(q_addr, WIN_LO, WIN_HI);
  assign hit_seg = (q_addr >= seg_base) && (q_addr < SEG_TOP);

  always_comb begin
    r = pick_route(hit_seg, hit_win, q_smm,
                   win_ctl[WC_EN_BIT], win_ctl[WC_OPEN_BIT]);
  end

  assign route     = r;
  assign wr_en     = q_valid &&  q_write && (r != RT_DROP);
  assign fill_ones = q_valid && !q_write && (r == RT_DROP);
endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
  import smram_route_pkg::*;
#(
  parameter int            AW      = PA_W,
  parameter int            GRAN_W  = 20,
  parameter logic [AW-1:0] WIN_LO  = 32'h000A_0000,
  parameter logic [AW-1:0] WIN_HI  = 32'h000B_FFFF,
  parameter logic [AW-1:0] SEG_TOP = 32'hAB80_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_smm,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_route,
  output logic          rsp_wr_en,
  output logic          rsp_fill_ones
);
  logic [WC_W-1:0] win_ctl;
  logic [AW-1:0]   seg_base;
  logic            seg_lock;
  logic            ctl_wr_take;
  logic            seg_wr_take;
  logic            q_valid;
  logic [AW-1:0]   q_addr;
  logic            q_write;
  logic            q_smm;
  logic            hit_win;
  logic            hit_seg;

  smram_cfg_regs #(.AW(AW), .GRAN_W(GRAN_W), .SEG_TOP(SEG_TOP)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_ctl(win_ctl),
    .seg_base(seg_base), .seg_lock(seg_lock),
    .ctl_wr_take(ctl_wr_take), .seg_wr_take(seg_wr_take)
  );

  smram_req_stage #(.AW(AW)) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_smm(req_smm), .q_valid(q_valid),
    .q_addr(q_addr), .q_write(q_write), .q_smm(q_smm)
  );

  smram_route_logic #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
                      .SEG_TOP(SEG_TOP)) u_route (
    .q_valid(q_valid), .q_addr(q_addr), .q_write(q_write), .q_smm(q_smm),
    .win_ctl(win_ctl), .seg_base(seg_base), .route(rsp_route),
    .wr_en(rsp_wr_en), .fill_ones(rsp_fill_ones),
    .hit_win(hit_win), .hit_seg(hit_seg)
  );

  assign rsp_valid = q_valid;
  assign rsp_addr  = q_addr;
endmodule

// File: rtl/smram_route_dec_chk.sv
module smram_route_dec_chk
  import smram_route_pkg::*;
#(
  parameter int AW = PA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic [1:0]      rsp_route,
  input logic            rsp_wr_en,
  input logic            rsp_fill_ones,
  input logic [WC_W-1:0] win_ctl,
  input logic [AW-1:0]   seg_base,
  input logic            seg_lock,
  input logic            hit_seg,
  input logic            q_smm
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_ctl[WC_LOCK_BIT] |=> win_ctl[WC_LOCK_BIT] && $stable(win_ctl)); // R8
  AST_LOCK_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_ctl[WC_LOCK_BIT] |-> !win_ctl[WC_OPEN_BIT]); // R8
  AST_SEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    seg_lock |=> seg_lock && $stable(seg_base)); // R9
  AST_SEG_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hit_seg && !q_smm) |-> rsp_route == 2'b10); // R10
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_route == 2'b10) |-> !rsp_wr_en); // R11
  AST_ONES_ONLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fill_ones |-> (rsp_route == 2'b10) && rsp_valid); // R11
endmodule

bind smram_route_dec smram_route_dec_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_route(rsp_route), .rsp_wr_en(rsp_wr_en), .rsp_fill_ones(rsp_fill_ones),
  .win_ctl(win_ctl), .seg_base(seg_base), .seg_lock(seg_lock),
  .hit_seg(hit_seg), .q_smm(q_smm)
);

// File: tb/smram_route_dec_bench.sv
module smram_route_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_smm = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_route;
  logic        rsp_wr_en;
  logic        rsp_fill_ones;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  route;
    logic        wr;
    logic        ones;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench-side register model
  logic [7:0]  m_ctl = 8'h00;
  logic [31:0] m_base = 32'hAB80_0000;
  logic        m_lock = 1'b0;
  localparam logic [31:0] TOP = 32'hAB80_0000;

  always #5 clk = ~clk;

  smram_route_dec u_smram_route_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_smm(req_smm),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_route(rsp_route),
    .rsp_wr_en(rsp_wr_en), .rsp_fill_ones(rsp_fill_ones)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_route(input logic [31:0] a, input logic smm);
    bit in_seg;
    bit in_win;
    in_seg = (a >= m_base) && (a < TOP);
    in_win = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    if (in_seg) return smm ? 2'b00 : 2'b10;
    if (in_win) return (m_ctl[3] && (smm || m_ctl[6])) ? 2'b00 : 2'b01;
    return 2'b00;
  endfunction

  task automatic send(input logic [31:0] a, input logic w, input logic smm, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_smm = smm;
    e.addr  = a;
    e.route = model_route(a, smm);
    e.wr    = w && (e.route != 2'b10);
    e.ones  = !w && (e.route == 2'b10);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic one(input logic [31:0] a, input logic w, input logic smm, input string tag);
    send(a, w, smm, tag);
    idle();
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (!sel && !m_ctl[4]) begin
      m_ctl = d[7:0];
      if (d[4]) m_ctl[6] = 1'b0;
    end
    if (sel && !m_lock) begin
      m_base = {d[31:20], 20'h0};
      m_lock = d[0];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " addr"},  rsp_addr, e.addr);
        chk({e.tag, " route"}, {30'd0, rsp_route}, {30'd0, e.route});
        chk({e.tag, " wr_en"}, {31'd0, rsp_wr_en}, {31'd0, e.wr});
        chk({e.tag, " ones"},  {31'd0, rsp_fill_ones}, {31'd0, e.ones});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    cfg_check(1'b0, 32'h0000_0000, "R1 control reset");
    cfg_check(1'b1, 32'hAB80_0000, "R1 segment reset");

    // window disabled
    one(32'h0000_1000, 1'b0, 1'b0, "R3 low dram");
    one(32'h000A_0000, 1'b0, 1'b0, "R4 win lo nonsmm");
    one(32'h000B_0000, 1'b0, 1'b1, "R4 win smm disabled");
    one(32'h000B_FFFF, 1'b1, 1'b0, "R4 win hi write");

    // enable
    cfg_write(1'b0, 32'h0000_0008);
    cfg_check(1'b0, 32'h0000_0008, "R7 control readback");
    one(32'h000A_0000, 1'b0, 1'b1, "R5 smm dram");
    one(32'h000B_FFFF, 1'b1, 1'b1, "R5 smm write dram");
    one(32'h000A_8000, 1'b0, 1'b0, "R5 nonsmm video");
    one(32'h000C_0000, 1'b0, 1'b0, "R3 above window");
    one(32'h0009_FFFF, 1'b0, 1'b0, "R3 below window");

    // open
    cfg_write(1'b0, 32'h0000_0048);
    cfg_check(1'b0, 32'h0000_0048, "R7 open readback");
    one(32'h000A_8000, 1'b0, 1'b0, "R6 open nonsmm dram");
    one(32'h000B_FFFF, 1'b1, 1'b0, "R6 open write dram");

    // protected segment
    cfg_write(1'b1, 32'hAB00_0000);
    cfg_check(1'b1, 32'hAB00_0000, "R9 segment readback");
    one(32'hAB00_0000, 1'b0, 1'b0, "R10 seg base read drop");
    one(32'hAB00_0000, 1'b1, 1'b0, "R11 seg write drop");
    one(32'hAB7F_FFFF, 1'b0, 1'b0, "R10 seg top-1 drop");
    one(32'hAB40_0000, 1'b1, 1'b1, "R10 seg smm dram");
    one(32'hAB80_0000, 1'b0, 1'b0, "R10 seg top dram");
    one(32'hAAFF_FFFF, 1'b0, 1'b0, "R10 below base dram");

    // lock segment, then try to move it
    cfg_write(1'b1, 32'hAB00_0001);
    cfg_write(1'b1, 32'h1000_0000);
    cfg_check(1'b1, 32'hAB00_0001, "R9 locked segment unchanged");
    one(32'h1000_0000, 1'b0, 1'b0, "R9 old region free");
    one(32'hAB10_0000, 1'b0, 1'b0, "R9 locked seg still drops");

    // lock control together with open: open must clear
    cfg_write(1'b0, 32'h0000_0058);
    cfg_check(1'b0, 32'h0000_0018, "R8 lock clears open");
    one(32'h000A_8000, 1'b0, 1'b0, "R8 locked nonsmm video");
    cfg_write(1'b0, 32'h0000_0040);
    cfg_check(1'b0, 32'h0000_0018, "R8 locked write ignored");
    one(32'h000A_8000, 1'b1, 1'b0, "R8 reopen attempt video");
    one(32'h000A_8000, 1'b0, 1'b1, "R8 locked smm dram");

    // back-to-back burst
    send(32'h000A_0000, 1'b0, 1'b1, "R2 burst 0");
    send(32'hAB00_0010, 1'b0, 1'b0, "R2 burst 1");
    send(32'h0020_0000, 1'b1, 1'b0, "R2 burst 2");
    idle();
    repeat (3) @(negedge clk);
    chk("R2 all responses seen", sb.size(), 32'd0);
    chk("R2 idle no response", {31'd0, rsp_valid}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule